// File: doc/BRIEF.md
# Tiered Warp Register File

This block holds the register state for one warp of `NTHREADS` threads and is addressed through a single 8-bit register index. The top bits of the index choose one of four banks. The per-thread bank gives each thread its own private copy. The warp bank and the indirect bank are shared by the whole warp. The constant bank cannot be written by instructions. Every access carries a thread select, so one set of pins serves every thread of the warp.

There are two read ports and one write port. Reads are combinational. A write lands on the clock edge and is visible from the next cycle onward. Results aimed at a shared register count only when they come from the reference thread, which is chosen on `ref_tid`. Because the shared banks keep a single copy, every thread reads the value that the reference thread wrote. The constant bank is filled through its own load port. An instruction write to a constant index is dropped and reported as a one-cycle error flag.

The ports carry no back-pressure. The block accepts every read and every write in the cycle it is presented, so no valid/ready pair is needed. `ref_tid` is a plain configuration input and takes effect immediately.

Top module: `rf_tiered`

## Requirements
- R1: Index ranges select the banks as follows: indices 0..127 select per-thread registers, 128..159 select warp registers, 160..191 select indirect registers, and 192..255 select constants. Adjacent boundary indices (127/128, 159/160, 191/192) address distinct storage.
- R2: A write to a per-thread index (bit 7 clear) from thread t changes only thread t's copy of that register.
- R3: A write to a warp index (128..159) from the reference thread is seen by every thread select on both read ports.
- R4: A write to a warp or indirect index whose `wr_tid` differs from `ref_tid` is discarded, and the register keeps its value.
- R5: Indirect entry 160+k is storage of its own, separate from warp entry 128+k. It follows the same reference-thread write rule and is shared by all threads.
- R6: An instruction write to a constant index (192..255) leaves the constant unchanged. `err_const` is high for exactly the one cycle after such a write and low otherwise.
- R7: A load on the init port at `cinit_idx` k sets constant index 192+k, and the new value is readable from the next cycle.
- R8: Read data reflects storage in the same cycle. A read of the register being written in that cycle returns the old value, and the new value appears one cycle later.
- R9: Reset clears the per-thread, warp and indirect banks and `err_const`. Constants keep their contents across a reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tid | input | TW | Reference thread for shared-bank writes |
| rd0_tid | input | TW | Thread select, read port 0 |
| rd0_idx | input | 8 | Register index, read port 0 |
| rd0_data | output | DW | Read data, port 0 |
| rd1_tid | input | TW | Thread select, read port 1 |
| rd1_idx | input | 8 | Register index, read port 1 |
| rd1_data | output | DW | Read data, port 1 |
| wr_en | input | 1 | Instruction write request |
| wr_tid | input | TW | Thread issuing the write |
| wr_idx | input | 8 | Destination index |
| wr_data | input | DW | Write data |
| cinit_en | input | 1 | Constant load strobe |
| cinit_idx | input | 6 | Constant slot (index 192+k) |
| cinit_data | input | DW | Constant load data |
| err_const | output | 1 | One-cycle flag: the previous write targeted a constant |

## Verification
Any corruption in this block appears at a read port in the same cycle that the affected index is read. Examples are a shared entry that split per thread, a broadcast taken from the wrong thread, a constant overwritten by an instruction, and a boundary index decoded into the wrong bank. Timing faults appear one cycle after the write: a write that shows up too early or too late, or a missing or extra error flag. The reference model compares both read ports and the flag on every cycle. The reads concentrate on a few indices on each side of every bank boundary, so a stale or stray value is read back within a few cycles of the write that caused it. A mid-run reset then shows whether the constant contents survive while the other banks return to zero.

// File: rtl/rf_tiered_pkg.sv
package rf_tiered_pkg;
  localparam int IDX_W   = 8;
  localparam int THR_AW  = 7;   // 128 private registers per thread
  localparam int SHR_AW  = 6;   // 32 warp + 32 indirect
  localparam int CST_AW  = 6;   // 64 constants

  typedef enum logic [1:0] {
    BK_THREAD = 2'd0,
    BK_WARP   = 2'd1,
    BK_IND    = 2'd2,
    BK_CONST  = 2'd3
  } bank_e;

  function automatic bank_e bank_of(input logic [IDX_W-1:0] idx);
    if (!idx[7])     return BK_THREAD;
    else if (idx[6]) return BK_CONST;
    else if (idx[5]) return BK_IND;
    else             return BK_WARP;
  endfunction
endpackage

// File: rtl/rf_wr_route.sv
module rf_wr_route
  import rf_tiered_pkg::*;
#(
  parameter int NTHREADS = 4,
  parameter int TW = (NTHREADS > 1) ? $clog2(NTHREADS) : 1
) (
  input  logic             wr_en,
  input  logic [TW-1:0]    wr_tid,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TW-1:0]    ref_tid,
  output logic             thr_we,
  output logic             shr_we,
  output logic             const_hit
);
  bank_e bank;
  logic  tid_ok;

  always_comb begin
    bank      = bank_of(wr_idx);
    tid_ok    = int'(wr_tid) < NTHREADS;
    thr_we    = wr_en && (bank == BK_THREAD) && tid_ok;
    // shared banks take only the reference thread's result
    shr_we    = wr_en && ((bank == BK_WARP) || (bank == BK_IND)) && (wr_tid == ref_tid);
    const_hit = wr_en && (bank == BK_CONST);
  end
endmodule

// File: rtl/rf_thread_bank.sv
module rf_thread_bank
  import rf_tiered_pkg::*;
#(
  parameter int NTHREADS = 4,
  parameter int DW = 32,
  parameter int TW = (NTHREADS > 1) ? $clog2(NTHREADS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [TW-1:0]     wtid,
  input  logic [THR_AW-1:0] widx,
  input  logic [DW-1:0]     wdata,
  input  logic [TW-1:0]     r0tid,
  input  logic [THR_AW-1:0] r0idx,
  input  logic [TW-1:0]     r1tid,
  input  logic [THR_AW-1:0] r1idx,
  output logic [DW-1:0]     r0data,
  output logic [DW-1:0]     r1data
);
  localparam int NREG = 1 << THR_AW;

  logic [DW-1:0] per0 [NTHREADS];
  logic [DW-1:0] per1 [NTHREADS];

  for (genvar t = 0; t < NTHREADS; t++) begin : g_thr
    logic [DW-1:0] mem [NREG];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < NREG; i++) mem[i] <= '0;
      end else if (we && (wtid == TW'(t))) begin
        mem[widx] <= wdata;
      end
    end
    assign per0[t] = mem[r0idx];
    assign per1[t] = mem[r1idx];
  end

  always_comb begin
    r0data = '0;
    r1data = '0;
    for (int t = 0; t < NTHREADS; t++) begin
      if (r0tid == TW'(t)) r0data = per0[t];
      if (r1tid == TW'(t)) r1data = per1[t];
    end
  end
endmodule

// File: rtl/rf_shared_bank.sv
module rf_shared_bank
  import rf_tiered_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SHR_AW-1:0] widx,
  input  logic [DW-1:0]     wdata,
  input  logic [SHR_AW-1:0] r0idx,
  input  logic [SHR_AW-1:0] r1idx,
  output logic [DW-1:0]     r0data,
  output logic [DW-1:0]     r1data
);
  localparam int NREG = 1 << SHR_AW;

  // lower half: warp registers, upper half: indirect entries
  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  assign r0data = mem[r0idx];
  assign r1data = mem[r1idx];
endmodule

// File: rtl/rf_const_bank.sv
module rf_const_bank
  import rf_tiered_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              ld_en,
  input  logic [CST_AW-1:0] ld_idx,
  input  logic [DW-1:0]     ld_data,
  input  logic [CST_AW-1:0] r0idx,
  input  logic [CST_AW-1:0] r1idx,
  output logic [DW-1:0]     r0data,
  output logic [DW-1:0]     r1data
);
  localparam int NREG = 1 << CST_AW;

  logic [DW-1:0] mem [NREG];

  // no reset: contents survive a warp reset
  always_ff @(posedge clk) begin
    if (ld_en) mem[ld_idx] <= ld_data;
  end

  assign r0data = mem[r0idx];
  assign r1data = mem[r1idx];
endmodule

// File: rtl/rf_tiered.sv
module rf_tiered
  import rf_tiered_pkg::*;
#(
  parameter int NTHREADS = 4,
  parameter int DW = 32,
  localparam int TW = (NTHREADS > 1) ? $clog2(NTHREADS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TW-1:0]     ref_tid,
  input  logic [TW-1:0]     rd0_tid,
  input  logic [IDX_W-1:0]  rd0_idx,
  output logic [DW-1:0]     rd0_data,
  input  logic [TW-1:0]     rd1_tid,
  input  logic [IDX_W-1:0]  rd1_idx,
  output logic [DW-1:0]     rd1_data,
  input  logic              wr_en,
  input  logic [TW-1:0]     wr_tid,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DW-1:0]     wr_data,
  input  logic              cinit_en,
  input  logic [CST_AW-1:0] cinit_idx,
  input  logic [DW-1:0]     cinit_data,
  output logic              err_const
);
  logic          thr_we, shr_we, const_hit;
  logic [DW-1:0] thr_r0, thr_r1, shr_r0, shr_r1, cst_r0, cst_r1;

  rf_wr_route #(.NTHREADS(NTHREADS), .TW(TW)) u_route (
    .wr_en(wr_en), .wr_tid(wr_tid), .wr_idx(wr_idx), .ref_tid(ref_tid),
    .thr_we(thr_we), .shr_we(shr_we), .const_hit(const_hit)
  );

  rf_thread_bank #(.NTHREADS(NTHREADS), .DW(DW), .TW(TW)) u_thr (
    .clk(clk), .rst_n(rst_n), .we(thr_we), .wtid(wr_tid),
    .widx(wr_idx[THR_AW-1:0]), .wdata(wr_data),
    .r0tid(rd0_tid), .r0idx(rd0_idx[THR_AW-1:0]),
    .r1tid(rd1_tid), .r1idx(rd1_idx[THR_AW-1:0]),
    .r0data(thr_r0), .r1data(thr_r1)
  );

  rf_shared_bank #(.DW(DW)) u_shr (
    .clk(clk), .rst_n(rst_n), .we(shr_we),
    .widx(wr_idx[SHR_AW-1:0]), .wdata(wr_data),
    .r0idx(rd0_idx[SHR_AW-1:0]), .r1idx(rd1_idx[SHR_AW-1:0]),
    .r0data(shr_r0), .r1data(shr_r1)
  );

  rf_const_bank #(.DW(DW)) u_cst (
    .clk(clk), .ld_en(cinit_en), .ld_idx(cinit_idx), .ld_data(cinit_data),
    .r0idx(rd0_idx[CST_AW-1:0]), .r1idx(rd1_idx[CST_AW-1:0]),
    .r0data(cst_r0), .r1data(cst_r1)
  );

  always_comb begin
    unique case (bank_of(rd0_idx))
      BK_THREAD:      rd0_data = thr_r0;
      BK_WARP, BK_IND: rd0_data = shr_r0;
      default:        rd0_data = cst_r0;
    endcase
    unique case (bank_of(rd1_idx))
      BK_THREAD:      rd1_data = thr_r1;
      BK_WARP, BK_IND: rd1_data = shr_r1;
      default:        rd1_data = cst_r1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err_const <= 1'b0;
    else        err_const <= const_hit;
  end
endmodule

// File: rtl/rf_tiered_chk.sv
module rf_tiered_chk
  import rf_tiered_pkg::*;
#(
  parameter int NTHREADS = 4,
  parameter int DW = 32,
  parameter int TW = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [TW-1:0]     ref_tid,
  input logic [TW-1:0]     rd0_tid,
  input logic [IDX_W-1:0]  rd0_idx,
  input logic [DW-1:0]     rd0_data,
  input logic [IDX_W-1:0]  rd1_idx,
  input logic [DW-1:0]     rd1_data,
  input logic              wr_en,
  input logic [TW-1:0]     wr_tid,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [DW-1:0]     wr_data,
  input logic              cinit_en,
  input logic              err_const
);
  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_err_after_const_wr_R6: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (wr_en && wr_idx[7:6] == 2'b11) |=> err_const);

  assert_no_stray_err_R6: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !(wr_en && wr_idx[7:6] == 2'b11) |=> !err_const);

  assert_const_holds_R6: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (rd0_idx[7:6] == 2'b11 && rd0_idx == $past(rd0_idx) && !$past(cinit_en)) |-> $stable(rd0_data));

  assert_warp_uniform_R3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (rd0_idx[7:6] == 2'b10 && rd1_idx == rd0_idx) |-> rd0_data == rd1_data);

  assert_nonref_dropped_R4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (wr_en && wr_idx[7:6] == 2'b10 && wr_tid != ref_tid && rd0_idx == wr_idx)
      |=> (rd0_idx != $past(rd0_idx) || $stable(rd0_data)));

  assert_write_next_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (wr_en && !wr_idx[7] && int'(wr_tid) < NTHREADS && wr_tid == rd0_tid && wr_idx == rd0_idx)
      |=> (rd0_idx != $past(rd0_idx) || rd0_tid != $past(rd0_tid) || rd0_data == $past(wr_data)));
endmodule

bind rf_tiered rf_tiered_chk #(.NTHREADS(NTHREADS), .DW(DW), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_tid(ref_tid),
  .rd0_tid(rd0_tid), .rd0_idx(rd0_idx), .rd0_data(rd0_data),
  .rd1_idx(rd1_idx), .rd1_data(rd1_data),
  .wr_en(wr_en), .wr_tid(wr_tid), .wr_idx(wr_idx), .wr_data(wr_data),
  .cinit_en(cinit_en), .err_const(err_const)
);

// File: tb/sim_rf_tiered.sv
`timescale 1ns/1ps
module sim_rf_tiered;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  ref_tid = '0, rd0_tid = '0, rd1_tid = '0, wr_tid = '0;
  logic [7:0]  rd0_idx = '0, rd1_idx = '0, wr_idx = '0;
  logic [31:0] rd0_data, rd1_data, wr_data = '0, cinit_data = '0;
  logic        wr_en = 1'b0, cinit_en = 1'b0;
  logic [5:0]  cinit_idx = '0;
  logic        err_const;

  always #5 clk = ~clk;

  rf_tiered #(.NTHREADS(N), .DW(32)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_tid(ref_tid),
    .rd0_tid(rd0_tid), .rd0_idx(rd0_idx), .rd0_data(rd0_data),
    .rd1_tid(rd1_tid), .rd1_idx(rd1_idx), .rd1_data(rd1_data),
    .wr_en(wr_en), .wr_tid(wr_tid), .wr_idx(wr_idx), .wr_data(wr_data),
    .cinit_en(cinit_en), .cinit_idx(cinit_idx), .cinit_data(cinit_data),
    .err_const(err_const)
  );

  // behavioural reference state
  logic [31:0] m_thr [N][128];
  logic [31:0] m_shr [64];
  logic [31:0] m_cst [64];
  logic        m_err;
  int compared = 0, mismatched = 0;
  bit done = 0;

  function automatic logic [31:0] model_rd(logic [1:0] tid, logic [7:0] idx);
    if (idx < 128)      return m_thr[tid][idx[6:0]];
    else if (idx < 192) return m_shr[idx[5:0]];
    else                return m_cst[idx[5:0]];
  endfunction

  function automatic string class_tag(logic [7:0] idx);
    if (idx < 128)      return "R2";
    else if (idx < 160) return "R3";
    else if (idx < 192) return "R5";
    else                return "R7";
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int t = 0; t < N; t++) for (int i = 0; i < 128; i++) m_thr[t][i] = '0;
    for (int i = 0; i < 64; i++) m_shr[i] = '0;
    m_err = 1'b0;
  endtask

  // called just after a falling edge with inputs already set
  task automatic step(string tag);
    #1;
    chk(tag == "" ? class_tag(rd0_idx) : tag, "rd0", rd0_data, model_rd(rd0_tid, rd0_idx));
    chk(tag == "" ? class_tag(rd1_idx) : tag, "rd1", rd1_data, model_rd(rd1_tid, rd1_idx));
    chk(tag == "" ? "R6" : tag, "err_const", {31'b0, err_const}, {31'b0, m_err});
    @(posedge clk);
    if (wr_en) begin
      if (wr_idx < 128) m_thr[wr_tid][wr_idx[6:0]] = wr_data;
      else if (wr_idx < 192) begin
        if (wr_tid == ref_tid) m_shr[wr_idx[5:0]] = wr_data;
      end
    end
    if (cinit_en) m_cst[cinit_idx] = cinit_data;
    m_err = wr_en && (wr_idx >= 192);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; cinit_en = 1'b0;
    repeat (3) @(negedge clk);
    clear_model();
    rst_n = 1'b1;
  endtask

  function automatic logic [7:0] pick_idx();
    int reg_sel = $urandom % 4;
    int off = (($urandom % 8) == 0) ? 31 : ($urandom % 4);
    case (reg_sel)
      0: return (off == 31) ? 8'd127 : 8'(off);
      1: return 8'(128 + off);
      2: return 8'(160 + off);
      default: return (off == 31) ? 8'd255 : 8'(192 + off);
    endcase
  endfunction

  task automatic random_run(int cycles);
    for (int c = 0; c < cycles; c++) begin
      rd0_tid = 2'($urandom); rd1_tid = 2'($urandom);
      rd0_idx = pick_idx();   rd1_idx = pick_idx();
      wr_en = ($urandom % 3) != 0;
      wr_tid = 2'($urandom); wr_idx = pick_idx(); wr_data = $urandom;
      cinit_en = ($urandom % 8) == 0;
      cinit_idx = 6'($urandom % 4); cinit_data = $urandom;
      if (($urandom % 16) == 0) ref_tid = 2'($urandom);
      step("");
    end
    wr_en = 1'b0; cinit_en = 1'b0;
  endtask

  initial begin
    clear_model();
    for (int i = 0; i < 64; i++) m_cst[i] = '0;
    do_reset();
    // R9: cleared banks after reset
    for (int t = 0; t < N; t++) begin
      rd0_tid = 2'(t); rd0_idx = 8'd5; rd1_tid = 2'(t); rd1_idx = 8'd140 + 8'(t * 8);
      step("R9");
    end
    // R7: load every constant
    for (int i = 0; i < 64; i++) begin
      cinit_en = 1'b1; cinit_idx = 6'(i); cinit_data = 32'hC0DE_0000 + i;
      rd0_idx = 8'd170; rd1_idx = 8'd3;
      step("R7");
    end
    cinit_en = 1'b0;
    rd0_idx = 8'd192; rd1_idx = 8'd255; step("R7");
    // R1: boundary indices
    ref_tid = 2'd0;
    wr_en = 1'b1; wr_tid = 2'd0;
    wr_idx = 8'd127; wr_data = 32'h1111_0127; step("R1");
    wr_idx = 8'd128; wr_data = 32'h2222_0128; step("R1");
    wr_idx = 8'd159; wr_data = 32'h3333_0159; step("R1");
    wr_idx = 8'd160; wr_data = 32'h4444_0160; step("R1");
    wr_idx = 8'd191; wr_data = 32'h5555_0191; step("R1");
    wr_en = 1'b0;
    rd0_tid = 2'd0; rd0_idx = 8'd127; rd1_idx = 8'd128; step("R1");
    rd0_idx = 8'd159; rd1_idx = 8'd160; step("R1");
    rd0_idx = 8'd191; rd1_idx = 8'd192; step("R1");
    // R2: private copy per thread
    wr_en = 1'b1; wr_tid = 2'd2; wr_idx = 8'd9; wr_data = 32'hABCD_0009; step("R2");
    wr_en = 1'b0; rd0_tid = 2'd2; rd0_idx = 8'd9; rd1_tid = 2'd1; rd1_idx = 8'd9; step("R2");
    // R3: reference broadcast seen by all threads
    ref_tid = 2'd3; wr_en = 1'b1; wr_tid = 2'd3; wr_idx = 8'd133; wr_data = 32'h0BAD_F00D; step("R3");
    wr_en = 1'b0; rd0_tid = 2'd0; rd0_idx = 8'd133; rd1_tid = 2'd2; rd1_idx = 8'd133; step("R3");
    // R4: non-reference warp/indirect writes discarded
    wr_en = 1'b1; wr_tid = 2'd1; wr_idx = 8'd133; wr_data = 32'hDEAD_0001; step("R4");
    wr_idx = 8'd165; wr_data = 32'hDEAD_0002; step("R4");
    wr_en = 1'b0; rd0_idx = 8'd133; rd1_idx = 8'd165; step("R4");
    // R5: indirect entry independent of its warp partner
    wr_en = 1'b1; wr_tid = 2'd3; wr_idx = 8'd165; wr_data = 32'h0000_0165; step("R5");
    wr_en = 1'b0; rd0_idx = 8'd133; rd1_idx = 8'd165; step("R5");
    // R6: constant write ignored, error one cycle later
    wr_en = 1'b1; wr_tid = 2'd3; wr_idx = 8'd200; wr_data = 32'hFFFF_FFFF;
    rd0_idx = 8'd200; step("R6");
    wr_en = 1'b0; step("R6");
    step("R6");
    // R8: read during write returns old value, new value next cycle
    wr_en = 1'b1; wr_tid = 2'd1; wr_idx = 8'd40; wr_data = 32'h7777_0040;
    rd0_tid = 2'd1; rd0_idx = 8'd40; step("R8");
    wr_en = 1'b0; step("R8");
    random_run(4000);
    // R9: reset clears warp state but keeps constants
    do_reset();
    rd0_idx = 8'd133; rd1_idx = 8'd192; step("R9");
    rd0_idx = 8'd40; rd0_tid = 2'd1; rd1_idx = 8'd255; step("R9");
    random_run(4000);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL R8 watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule